// File: doc/BRIEF.md
# Gated-Window Decimal Frequency Meter

This block measures how often a digital signal toggles. It counts the rising edges of that signal during a counting window of exactly one second. The window is derived from the system clock, so the count it reports equals the frequency in hertz. The measured signal is brought into the system-clock domain through a two-stage synchronizer. Its rising edges are found there, and all logic runs on that one clock.

Each measurement period lasts two seconds. For the first second the gate is open and edges are counted. For the second second the gate is closed and the count is frozen. Near the end of the closed half, a single-cycle load pulse copies the count into a result register. On the next cycle a single-cycle clear pulse resets the counter for the next window. The count is kept as packed decimal digits, four bits per digit, with the least significant digit in the lowest bits. A count that would pass the largest value the digits can show stops at all nines and raises an overflow flag. That flag is reported together with the result.

Top module: `fm_meter`

## Requirements
- R1: After reset is released the gate is open for exactly CLK_HZ system-clock cycles. It is then closed for CLK_HZ cycles, and this two-second period repeats without end.
- R2: While the gate is open, each rising edge of `sig_in` raises the count by one. An edge takes effect after two synchronizer stages and one edge-detect stage.
- R3: The count is DIGITS packed decimal digits, each held in 0..9. Digit 0 sits in bits 3:0 and digit k in bits 4k+3:4k. A digit that wraps from 9 to 0 carries one into the next digit up.
- R4: While the gate is closed, edges on `sig_in` are ignored and the count holds.
- R5: The result register is loaded only while the gate is closed, once per period. `result_valid` is high for exactly one cycle, the first cycle in which the new result is visible. `result` does not change in any other cycle.
- R6: The load happens on the cycle before the clear, so the reported value is the full count of the window just ended. The next window then counts from zero.
- R7: If an increment would take the count past all nines, the count stays at all nines and a sticky overflow flag is set. The flag is reported on `result_ovf` with that window's result. The clear pulse resets the flag.
- R8: Synchronous active-high reset sets `result` to zero and drops `result_ovf` and `result_valid`. It also restarts the timing so that the first cycle after reset begins an open-gate window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Signal to measure, asynchronous to clk |
| result | output | 4*DIGITS | Last measured count, packed decimal digits |
| result_ovf | output | 1 | Overflow flag captured with `result` |
| result_valid | output | 1 | One-cycle strobe when `result` is reloaded |

## Verification
The assertions assume that `sig_in` stays high and low for at least one system-clock cycle each. Faster toggling would be lost in the synchronizer, and the edge count could no longer be matched. The stimulus drives the signal on the falling clock edge with pulses two cycles long. It places the counted bursts well inside the open half of each period and the ignored bursts well inside the closed half. This keeps the synchronizer latency from moving an edge across a gate boundary. A reduced CLK_HZ and two digits make overflow reachable in a single window.

// File: rtl/fm_pkg.sv
package fm_pkg;

    // Control strobes issued by the window timer in one cycle
    typedef struct packed {
        logic gate;   // counting window open
        logic load;   // copy count into result register
        logic wipe;   // reset the counter
    } fm_ctrl_t;

    localparam logic [3:0] DEC_MAX = 4'd9;

    // Next value of a decimal digit when stepped
    function automatic logic [3:0] dec_step(input logic [3:0] d);
        return (d == DEC_MAX) ? 4'd0 : d + 4'd1;
    endfunction

    // Width of a counter that reaches n-1
    function automatic int cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fm_window_timer.sv
module fm_window_timer
    import fm_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic     clk,
    input  logic     rst,
    output fm_ctrl_t ctrl
);
    localparam int unsigned PERIOD = 2 * CLK_HZ;
    localparam int          CW     = cnt_width(PERIOD);
    localparam logic [CW-1:0] LAST     = CW'(PERIOD - 1);
    localparam logic [CW-1:0] OPEN_END = CW'(CLK_HZ);
    localparam logic [CW-1:0] LOAD_AT  = CW'(PERIOD - 3);
    localparam logic [CW-1:0] WIPE_AT  = CW'(PERIOD - 2);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    always_comb begin
        ctrl.gate = (phase < OPEN_END);
        ctrl.load = (phase == LOAD_AT);
        ctrl.wipe = (phase == WIPE_AT);
    end

    AST_GATE_OPENS_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ctrl.gate);                                     // R8
    AST_LOAD_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        ctrl.load |-> !ctrl.gate);                                     // R5
    AST_LOAD_THEN_WIPE: assert property (@(posedge clk) disable iff (rst)
        ctrl.load |=> ctrl.wipe && !ctrl.gate);                        // R6
    AST_WIPE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.wipe) |-> $past(ctrl.load));                        // R6
    AST_GATE_REOPENS: assert property (@(posedge clk) disable iff (rst)
        ctrl.wipe |=> !ctrl.gate ##1 ctrl.gate);                       // R1

endmodule

// File: rtl/fm_edge_sync.sv
module fm_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [2:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[1:0], async_in};
    end

    assign rise = stg[1] & ~stg[2];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);                                               // R2

endmodule

// File: rtl/fm_dec_counter.sv
module fm_dec_counter
    import fm_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              step,
    output logic [4*DIGITS-1:0] count,
    output logic              ovf
);
    localparam int W = 4 * DIGITS;

    logic [DIGITS:0] carry;
    logic            sat;

    assign carry[0] = step;
    assign sat      = carry[DIGITS];

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig;
        assign carry[g+1] = carry[g] && (dig == DEC_MAX);

        always_ff @(posedge clk) begin
            if (rst || wipe)              dig <= 4'd0;
            else if (carry[g] && !sat)    dig <= dec_step(dig);
        end

        assign count[4*g +: 4] = dig;

        AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
            dig <= DEC_MAX);                                           // R3
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) ovf <= 1'b0;
        else if (sat)    ovf <= 1'b1;
    end

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        !step && !wipe |=> $stable(count));                            // R4
    AST_WIPED: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (count == '0) && !ovf);                               // R6
    AST_SATURATED: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count == {DIGITS{4'd9}}));                            // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        step && !wipe && (count == {DIGITS{4'd9}}) |=> count == {DIGITS{4'd9}}); // R7

    logic unused_w;
    assign unused_w = (W == 0);

endmodule

// File: rtl/fm_meter.sv
module fm_meter
    import fm_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000,
    parameter int          DIGITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sig_in,
    output logic [4*DIGITS-1:0] result,
    output logic                result_ovf,
    output logic                result_valid
);
    localparam int W = 4 * DIGITS;

    fm_ctrl_t      ctrl;
    logic          rise;
    logic          step;
    logic          load_en;
    logic          wipe_en;
    logic [W-1:0]  count;
    logic          ovf;

    fm_window_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl)
    );

    fm_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sig_in),
        .rise     (rise)
    );

    assign step    = ctrl.gate && rise;
    assign load_en = ctrl.load && !ctrl.gate;
    assign wipe_en = ctrl.wipe && !ctrl.gate;

    fm_dec_counter #(.DIGITS(DIGITS)) u_count (
        .clk   (clk),
        .rst   (rst),
        .wipe  (wipe_en),
        .step  (step),
        .count (count),
        .ovf   (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            result_ovf   <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= load_en;
            if (load_en) begin
                result     <= count;
                result_ovf <= ovf;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);                               // R5
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result) && $stable(result_ovf));     // R5
    AST_NO_COUNT_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !ctrl.gate && !wipe_en |=> $stable(count));                    // R4

endmodule

// File: tb/tb_fm_meter.sv
module tb_fm_meter;
    localparam int unsigned CLK_HZ = 400;
    localparam int          DIGITS = 2;
    localparam int          W      = 4 * DIGITS;
    localparam int          PERIOD = 2 * CLK_HZ;
    localparam int          MAXV   = 99;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sig_in = 1'b0;
    logic [W-1:0] result;
    logic         result_ovf;
    logic         result_valid;

    int total = 0;
    int bad   = 0;
    int n_valid = 0;
    bit done  = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;

    fm_meter #(.CLK_HZ(CLK_HZ), .DIGITS(DIGITS)) dut (
        .clk          (clk),
        .rst          (rst),
        .sig_in       (sig_in),
        .result       (result),
        .result_ovf   (result_ovf),
        .result_valid (result_valid)
    );

    function automatic logic [W-1:0] to_dec(input int v);
        logic [W-1:0] r = '0;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse();
        sig_in = 1'b1;
        @(negedge clk);
        sig_in = 1'b0;
        @(negedge clk);
    endtask

    // Driver: one full period; n edges counted, m edges in the closed half
    task automatic run_window(input int n, input int m);
        int used = 0;
        exp_q.push_back(n);
        repeat (10) @(negedge clk);
        used = 10;
        for (int i = 0; i < n; i++) pulse();          // R2, R3
        used += 2 * n;
        while (used < CLK_HZ + 20) begin @(negedge clk); used++; end
        for (int i = 0; i < m; i++) pulse();          // R4 ignored edges
        used += 2 * m;
        while (used < PERIOD) begin @(negedge clk); used++; end
    endtask

    // Monitor: compares each loaded result with the scoreboard
    always @(negedge clk) begin
        if (!rst && result_valid) begin
            int n;
            n_valid++;
            if (exp_q.size() == 0) begin
                check("R5 unexpected load", 1, 0);
            end else begin
                n = exp_q.pop_front();
                check("R2/R3/R6 result", int'(result),
                      int'(to_dec(n > MAXV ? MAXV : n)));
                check("R7 overflow flag", int'(result_ovf), (n > MAXV) ? 1 : 0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8 reset state
        check("R8 result at reset", int'(result), 0);
        check("R8 ovf at reset", int'(result_ovf), 0);
        check("R8 valid at reset", int'(result_valid), 0);
        rst = 1'b0;
        // R1 timing is implied by which bursts count
        run_window(0, 5);
        run_window(1, 0);
        run_window(9, 30);
        run_window(10, 3);
        run_window(57, 60);
        run_window(99, 10);
        run_window(100, 0);     // R7 just past full scale
        run_window(150, 40);    // R7 well past
        run_window(5, 70);      // R7 flag cleared by wipe, R6 restart from zero
        repeat (20) @(negedge clk);
        check("R5 loads per period", n_valid, 9);
        check("R5 pending results", exp_q.size(), 0);
        check("R5 valid idle", int'(result_valid), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule